// File: doc/BRIEF.md
# Audio Serial Clock Strobe Divider

This block derives a periodic clock-enable strobe for an audio serial interface from the parent clock it runs on. Software programs one 32-bit control word: the upper half carries an unsigned 16-bit divide ratio and the two lowest bits are a pair of enable flags. While both flags are set and the ratio is a legal value, the block counts parent cycles and raises a one-cycle strobe once every ratio cycles. Downstream logic uses this strobe as the tick of the serial bit clock.

A status output reports whether the divider is running. Software stops the divider by writing an all-zero word. That write also discards the stored ratio, so the ratio must be written again before the next start. Each write restarts the count from zero, so the cadence of the strobe always begins at the most recent write.

Top module: `aud_sclk_div`

## Requirements
- R1: After a synchronous reset, the read data is 0x00000000, the strobe is low and the status output is low.
- R2: A write stores bits 31:16 (ratio) and bits 1:0 (enables) of the write data. On the next cycle the read data shows those fields, and bits 15:2 always read as zero.
- R3: The divider runs only while enable bits 1:0 both equal 1. With any other enable value (0, 1 or 2) the strobe stays low.
- R4: A ratio of 0 or 1 never produces a strobe, even when both enable bits are set.
- R5: While running with ratio N (2 to 65535), the strobe is exactly one cycle wide and rises every N cycles. The first strobe comes N cycles after the write edge.
- R6: The status output is high exactly when both enable bits are set and the stored ratio is at least 2, and it changes in the same cycle as the read data.
- R7: A write while running restarts the count. The next strobe comes N cycles after that write edge, where N is the newly written ratio.
- R8: On a cycle where a write is accepted, no strobe is produced, including when the counter is at its terminal count.
- R9: Writing zero stops the strobe, drops the status output and clears the stored ratio to zero.
- R10: The maximum ratio of 65535 gives a strobe period of exactly 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Stored control word (reserved bits zero) |
| strobe | output | 1 | One-cycle clock-enable pulse, once per ratio cycles |
| active | output | 1 | High while the divider is running |

## Verification
A register write and the counter's terminal count can land on the same edge, and that is where a reload and a strobe compete. The bench runs the counter up to the cycle just before its wrap and issues a write at that moment. It then expects the strobe to stay low on that edge and the next strobe to follow the new ratio, counted from the write. The same collision is also provoked mid-period, and every ratio from 0 to 7 under all four enable patterns is compared cycle by cycle against an edge counter kept in the bench.

// File: rtl/aud_sclk_div_pkg.sv
package aud_sclk_div_pkg;

  // Divider state as seen by the counter
  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  localparam int unsigned MIN_RATIO = 2;

endpackage

// File: rtl/aud_sclk_div_reg.sv
module aud_sclk_div_reg #(
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned EN_W    = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctl_q,
  output logic              run_q
);
  import aud_sclk_div_pkg::*;

  localparam int unsigned RSV_W = DATA_W - RATIO_W - EN_W;
  localparam logic [DATA_W-1:0] KEEP_MASK =
    {{RATIO_W{1'b1}}, {RSV_W{1'b0}}, {EN_W{1'b1}}};

  logic [DATA_W-1:0]  ctl_d;
  logic [RATIO_W-1:0] ratio_d;
  logic [EN_W-1:0]    en_d;
  logic               ratio_ok_d;
  logic               en_all_d;

  always_comb begin
    if (wr_en) ctl_d = wr_data & KEEP_MASK;
    else       ctl_d = ctl_q;
  end

  assign ratio_d    = ctl_d[DATA_W-1 -: RATIO_W];
  assign en_d       = ctl_d[EN_W-1:0];
  assign ratio_ok_d = (ratio_d >= RATIO_W'(MIN_RATIO));
  assign en_all_d   = &en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      run_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      run_q <= en_all_d && ratio_ok_d;
    end
  end

endmodule

// File: rtl/aud_sclk_div_cnt.sv
module aud_sclk_div_cnt #(
  parameter int unsigned RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               strobe_q
);
  import aud_sclk_div_pkg::*;

  logic [RATIO_W-1:0] cnt_q;
  logic               at_end;
  div_state_e         state;

  assign state  = run ? DIV_RUN : DIV_IDLE;
  assign at_end = (cnt_q == ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (restart || state == DIV_IDLE) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (at_end) begin
      cnt_q    <= '0;
      strobe_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + RATIO_W'(1);
      strobe_q <= 1'b0;
    end
  end

endmodule

// File: rtl/aud_sclk_div.sv
module aud_sclk_div #(
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned EN_W    = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              strobe,
  output logic              active
);

  logic [DATA_W-1:0] ctl_q;
  logic              run_q;

  aud_sclk_div_reg #(
    .RATIO_W(RATIO_W),
    .EN_W   (EN_W),
    .DATA_W (DATA_W)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .ctl_q  (ctl_q),
    .run_q  (run_q)
  );

  aud_sclk_div_cnt #(
    .RATIO_W(RATIO_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_en),
    .run     (run_q),
    .ratio   (ctl_q[DATA_W-1 -: RATIO_W]),
    .strobe_q(strobe)
  );

  assign rd_data = ctl_q;
  assign active  = run_q;

endmodule

// File: rtl/aud_sclk_div_chk.sv
module aud_sclk_div_chk #(
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned EN_W    = 2,
  parameter int unsigned DATA_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              strobe,
  input logic              active
);
  localparam int unsigned RSV_W = DATA_W - RATIO_W - EN_W;
  localparam logic [DATA_W-1:0] KEEP_MASK =
    {{RATIO_W{1'b1}}, {RSV_W{1'b0}}, {EN_W{1'b1}}};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && !strobe && !active)); // R1

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & KEEP_MASK)); // R2

  AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(active)); // R3

  AST_ACTIVE_DECODE: assert property (@(posedge clk) disable iff (rst)
    active == ((&rd_data[EN_W-1:0]) &&
               (rd_data[DATA_W-1 -: RATIO_W] >= RATIO_W'(2)))); // R6

  AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe); // R5

  AST_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !strobe); // R8

  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == '0) |=> (!active && rd_data == '0)); // R9

endmodule

bind aud_sclk_div aud_sclk_div_chk #(
  .RATIO_W(RATIO_W),
  .EN_W   (EN_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .strobe (strobe),
  .active (active)
);

// File: tb/aud_sclk_div_tb.sv
module aud_sclk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        strobe;
  logic        active;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int k        = 0;     // edges since last write
  int cur_n    = 0;     // ratio written last
  bit cur_run  = 1'b0;

  aud_sclk_div u_dut (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .strobe (strobe),
    .active (active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d ratio %0d)", req, act, exp, k, cur_n);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // Write a word and check the cycle right after the write edge
  task automatic write_word(input logic [31:0] w);
    wr_en   = 1'b1;
    wr_data = w;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
    k       = 0;
    cur_n   = int'(w[31:16]);
    cur_run = (w[1:0] == 2'b11) && (cur_n >= 2);
    chk(rd_data == (w & 32'hFFFF_0003), "R2", rd_data, w & 32'hFFFF_0003);
    chk(active == cur_run, "R6", active, cur_run);
    chk(strobe == 1'b0, "R8", strobe, 0);
  endtask

  // Advance one cycle and compare the strobe with the arithmetic model
  task automatic step(input string req);
    bit exp;
    @(posedge clk);
    @(negedge clk);
    k++;
    exp = cur_run && (k % cur_n == 0);
    chk(strobe == exp, req, strobe, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rd_data == 32'h0, "R1", rd_data, 0);
    chk(strobe == 1'b0, "R1", strobe, 0);
    chk(active == 1'b0, "R1", active, 0);

    // R2: reserved bits read as zero
    write_word(32'hFFFF_FFFF);
    step("R5");

    // Sweep ratios 0..7 under all enable patterns
    for (int r = 0; r < 8; r++) begin
      for (int e = 0; e < 4; e++) begin
        string tag;
        if (e != 3)     tag = "R3";
        else if (r < 2) tag = "R4";
        else            tag = "R5";
        write_word({16'(r), 14'h2A5A, 2'(e)});
        for (int c = 0; c < 3 * 8 + 2; c++) step(tag);
      end
    end

    // R7: mid-period rewrite restarts with the new ratio
    write_word({16'd6, 16'h0003});
    step("R7"); step("R7");
    write_word({16'd3, 16'h0003});
    for (int c = 0; c < 10; c++) step("R7");

    // R8: write lands exactly on the terminal-count edge
    write_word({16'd4, 16'h0003});
    for (int c = 0; c < 3; c++) step("R8");
    write_word({16'd5, 16'h0003});
    for (int c = 0; c < 12; c++) step("R8");

    // R9: zero write stops and clears the ratio
    write_word(32'h0);
    chk(rd_data[31:16] == 16'h0, "R9", rd_data, 0);
    for (int c = 0; c < 8; c++) step("R9");
    write_word(32'h0000_0003);
    chk(active == 1'b0, "R9", active, 0);
    for (int c = 0; c < 4; c++) step("R9");

    // R10: maximum ratio, one full period plus a few cycles
    write_word({16'hFFFF, 16'h0003});
    for (int c = 0; c < 65535 + 4; c++) step("R10");

    finish_run();
  end
endmodule